// File: doc/BRIEF.md
# Warm-Boot Command Sequencer

This block makes a running FPGA reload itself from another location in its configuration flash. On a single start pulse it drives the device's internal 32-bit configuration port with a fixed burst of eight writes. The burst opens with a dummy word and the synchronisation word. It then writes the chosen flash address into the warm-boot start-address register. It ends by writing the reload command into the command register. After that last write the device re-initialises and boots from the new address.

The configuration port takes each byte with its bits in mirrored order, so every word is bit-reversed inside each of its four bytes on the way out. The target address is captured when the start pulse is accepted, which means the caller may change the address input freely once the burst has begun. A stall input can pause the burst at any word. During a pause the port enable is released and the current word is held on the bus until the stall clears.

Top module: `warmboot_seq`

## Requirements
- R1: Out of reset and whenever not busy, `cfg_en_n_o` is 1, `cfg_wr_n_o` is 1, `cfg_data_o` is all ones and `busy_o` is 0.
- R2: An accepted start produces exactly eight enabled writes, with these values before reordering: 0xFFFFFFFF, 0xAA995566, 0x20000000, 0x30020001, the target address, 0x30008001, 0x0000000F, 0x20000000.
- R3: Port bit 8*b+j carries bit 8*b+(7-j) of the word, for every byte b in 0..3 and every bit j in 0..7.
- R4: Each enabled word lasts one clock cycle with `cfg_en_n_o`=0 and `cfg_wr_n_o`=0. The first word appears in the cycle after the clock edge that samples `start_i` high while idle. With no stall, the words follow one another on consecutive cycles.
- R5: While `stall_i` is 1 during a burst, `cfg_en_n_o` is 1, `cfg_wr_n_o` stays 0, the current word stays on `cfg_data_o`, and the sequence does not advance.
- R6: A start pulse sampled while `busy_o` is 1, including in the final busy cycle, is ignored: no extra words are written and the block returns to idle.
- R7: The target address is sampled on the accepted start. Changes to `target_addr_i` afterwards do not alter the address word of the current burst.
- R8: `busy_o` is 1 from the first word through exactly one cycle after the last word. In that extra cycle the enable is high. `busy_o` is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that requests a reload burst |
| target_addr_i | input | 32 | Flash address to boot from |
| stall_i | input | 1 | Pauses the burst and holds the current word |
| cfg_data_o | output | 32 | Bit-reordered word to the configuration port |
| cfg_en_n_o | output | 1 | Port enable, active low |
| cfg_wr_n_o | output | 1 | 0 selects write, 1 selects read |
| busy_o | output | 1 | Burst in progress |

## Verification
Two events can land on the same edge: a new start request and the end of a burst. The bench raises `start_i` on the last word and again in the extra busy cycle, where `busy_o` is about to drop. It passes only if the block goes idle, writes no ninth word, and stays idle one cycle later. A stall on the final word also lands on the same edge as the move into the extra busy cycle. Here the bench checks that the word is held and that the extra busy cycle still follows exactly once.

// File: rtl/wb_pkg.sv
package wb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_TAIL = 2'd2
   } seq_state_e;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned SEQ_LEN  = 8;
   localparam int unsigned ADDR_POS = 4;

   localparam logic [WORD_W-1:0] W_DUMMY  = 32'hFFFF_FFFF;
   localparam logic [WORD_W-1:0] W_SYNC   = 32'hAA99_5566;
   localparam logic [WORD_W-1:0] W_NOOP   = 32'h2000_0000;
   localparam logic [WORD_W-1:0] W_HDR_SA = 32'h3002_0001;
   localparam logic [WORD_W-1:0] W_HDR_CM = 32'h3000_8001;
   localparam logic [WORD_W-1:0] W_RELOAD = 32'h0000_000F;
endpackage

// File: rtl/wb_word_sel.sv
module wb_word_sel #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 3
) (
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] addr_i,
   output logic [DATA_W-1:0] word_o
);
   import wb_pkg::*;

   always_comb begin
      unique case (idx_i)
         3'd0:    word_o = W_DUMMY;
         3'd1:    word_o = W_SYNC;
         3'd2:    word_o = W_NOOP;
         3'd3:    word_o = W_HDR_SA;
         3'd4:    word_o = addr_i;
         3'd5:    word_o = W_HDR_CM;
         3'd6:    word_o = W_RELOAD;
         default: word_o = W_NOOP;
      endcase
   end
endmodule

// File: rtl/wb_bit_order.sv
module wb_bit_order #(
   parameter int unsigned DATA_W  = 32,
   parameter bit          SWAP_EN = 1'b1
) (
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o
);
   localparam int unsigned NBYTES = DATA_W / 8;

   if (SWAP_EN) begin : g_swap
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         for (genvar j = 0; j < 8; j++) begin : g_bit
            assign dout_o[8*b + j] = din_i[8*b + 7 - j];
         end
      end
   end else begin : g_pass
      assign dout_o = din_i;
   end
endmodule

// File: rtl/wb_seq_ctrl.sv
module wb_seq_ctrl #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SEQ_LEN = 8,
   localparam int unsigned IDX_W  = $clog2(SEQ_LEN)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [DATA_W-1:0]    addr_i,
   input  logic                 stall_i,
   output wb_pkg::seq_state_e   state_o,
   output logic [IDX_W-1:0]     idx_o,
   output logic [DATA_W-1:0]    addr_q_o
);
   import wb_pkg::*;

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

   seq_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] addr_q;
   logic              advance;

   assign advance = (state_q == ST_SEND) && !stall_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         addr_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_SEND;
                  idx_q   <= '0;
                  addr_q  <= addr_i;
               end
            end
            ST_SEND: begin
               if (advance) begin
                  if (idx_q == LAST_IDX) begin
                     state_q <= ST_TAIL;
                     idx_q   <= '0;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o  = state_q;
   assign idx_o    = idx_q;
   assign addr_q_o = addr_q;
endmodule

// File: rtl/warmboot_seq.sv
module warmboot_seq #(
   parameter int unsigned DATA_W   = 32,
   parameter bit          SWAP_EN  = 1'b1,
   parameter bit          STALL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] target_addr_i,
   input  logic              stall_i,
   output logic [DATA_W-1:0] cfg_data_o,
   output logic              cfg_en_n_o,
   output logic              cfg_wr_n_o,
   output logic              busy_o
);
   import wb_pkg::*;

   localparam int unsigned SEQ_N = SEQ_LEN;
   localparam int unsigned IDX_W = $clog2(SEQ_N);

   if (DATA_W != WORD_W) begin : g_bad_width
      $error("warmboot_seq: DATA_W must equal the 32-bit port width");
   end
   if ((DATA_W % 8) != 0) begin : g_bad_bytes
      $error("warmboot_seq: DATA_W must be a whole number of bytes");
   end

   seq_state_e        state;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] addr_q;
   logic [DATA_W-1:0] word;
   logic [DATA_W-1:0] word_sw;
   logic              stall_eff;
   logic              sending;

   if (STALL_EN) begin : g_stall
      assign stall_eff = stall_i;
   end else begin : g_nostall
      assign stall_eff = 1'b0;
   end

   wb_seq_ctrl #(
      .DATA_W  (DATA_W),
      .SEQ_LEN (SEQ_N)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .addr_i   (target_addr_i),
      .stall_i  (stall_eff),
      .state_o  (state),
      .idx_o    (idx),
      .addr_q_o (addr_q)
   );

   wb_word_sel #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_sel (
      .idx_i  (idx),
      .addr_i (addr_q),
      .word_o (word)
   );

   wb_bit_order #(
      .DATA_W  (DATA_W),
      .SWAP_EN (SWAP_EN)
   ) u_order (
      .din_i  (word),
      .dout_o (word_sw)
   );

   assign sending    = (state == ST_SEND);
   assign busy_o     = (state != ST_IDLE);
   assign cfg_en_n_o = !(sending && !stall_eff);
   assign cfg_wr_n_o = !busy_o;
   assign cfg_data_o = sending ? word_sw : '1;
endmodule

// File: rtl/wb_seq_chk.sv
module wb_seq_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stall_i,
   input logic [DATA_W-1:0] cfg_data_o,
   input logic              cfg_en_n_o,
   input logic              cfg_wr_n_o,
   input logic              busy_o
);
   logic [3:0] wr_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wr_cnt <= '0;
      else if (!busy_o)    wr_cnt <= '0;
      else if (!cfg_en_n_o) wr_cnt <= wr_cnt + 1'b1;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cfg_en_n_o && cfg_wr_n_o && (cfg_data_o == '1))); // R1

   AST_EN_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en_n_o |-> (!cfg_wr_n_o && busy_o)); // R4

   AST_BUSY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !cfg_wr_n_o); // R4

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && stall_i) |=> (cfg_data_o == $past(cfg_data_o))); // R5

   AST_EIGHT_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (wr_cnt == 4'd8)); // R6

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt <= 4'd8); // R2

   AST_TAIL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(cfg_en_n_o)); // R8
endmodule

bind warmboot_seq wb_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stall_i    (stall_i),
   .cfg_data_o (cfg_data_o),
   .cfg_en_n_o (cfg_en_n_o),
   .cfg_wr_n_o (cfg_wr_n_o),
   .busy_o     (busy_o)
);

// File: tb/sim_warmboot_seq.sv
module sim_warmboot_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] target_addr_i = '0;
   logic        stall_i = 1'b0;
   logic [31:0] cfg_data_o;
   logic        cfg_en_n_o;
   logic        cfg_wr_n_o;
   logic        busy_o;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   logic [31:0] cap [0:15];
   int          cap_n = 0;

   always #10 clk = ~clk;

   warmboot_seq u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .target_addr_i (target_addr_i),
      .stall_i       (stall_i),
      .cfg_data_o    (cfg_data_o),
      .cfg_en_n_o    (cfg_en_n_o),
      .cfg_wr_n_o    (cfg_wr_n_o),
      .busy_o        (busy_o)
   );

   function automatic logic [31:0] mirror(input logic [31:0] w);
      logic [31:0] r;
      for (int b = 0; b < 4; b++)
         for (int j = 0; j < 8; j++)
            r[8*b + j] = w[8*b + 7 - j];
      return r;
   endfunction

   function automatic logic [31:0] expect_word(input int i, input logic [31:0] a);
      case (i)
         0: return 32'hFFFF_FFFF;
         1: return 32'hAA99_5566;
         2: return 32'h2000_0000;
         3: return 32'h3002_0001;
         4: return a;
         5: return 32'h3000_8001;
         6: return 32'h0000_000F;
         default: return 32'h2000_0000;
      endcase
   endfunction

   // simple port model: records each enabled write, undoing the bit order
   always @(posedge clk) begin
      if (rst_n && !cfg_en_n_o && !cfg_wr_n_o) begin
         if (cap_n < 16) cap[cap_n] = mirror(cfg_data_o);
         cap_n = cap_n + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(req, {31'd0, cfg_en_n_o}, 32'd1);
      chk(req, {31'd0, cfg_wr_n_o}, 32'd1);
      chk(req, cfg_data_o, 32'hFFFF_FFFF);
      chk(req, {31'd0, busy_o}, 32'd0);
   endtask

   task automatic run_seq(input logic [31:0] a, input logic [7:0] stall_at, input bit poke);
      cap_n = 0;
      @(negedge clk);
      start_i = 1'b1;
      target_addr_i = a;
      @(negedge clk);
      start_i = 1'b0;
      if (poke) target_addr_i = ~a;              // R7: change after capture
      for (int i = 0; i < 8; i++) begin
         if (stall_at[i]) begin
            stall_i = 1'b1;
            #1;
            chk("R5 en", {31'd0, cfg_en_n_o}, 32'd1);
            chk("R5 wr", {31'd0, cfg_wr_n_o}, 32'd0);
            chk("R5 hold", cfg_data_o, mirror(expect_word(i, a)));
            @(negedge clk);
            stall_i = 1'b0;
         end
         #1;
         chk("R4 en", {31'd0, cfg_en_n_o}, 32'd0);
         chk("R4 wr", {31'd0, cfg_wr_n_o}, 32'd0);
         chk("R3 word", cfg_data_o, mirror(expect_word(i, a)));
         start_i = poke && (i == 3 || i == 7);  // R6: start while busy
         @(negedge clk);
         start_i = 1'b0;
      end
      #1;
      chk("R8 tail busy", {31'd0, busy_o}, 32'd1);
      chk("R8 tail en", {31'd0, cfg_en_n_o}, 32'd1);
      start_i = poke;                            // R6: start in last busy cycle
      @(negedge clk);
      start_i = 1'b0;
      #1;
      chk_idle("R8 end");
      chk("R2 count", cap_n, 32'd8);
      for (int i = 0; i < 8; i++)
         chk("R2 value", cap[i], expect_word(i, a));
      chk("R7 addr", cap[4], a);
      @(negedge clk);
      #1;
      chk_idle("R6 stays idle");
      chk("R6 count", cap_n, 32'd8);
   endtask

   initial begin
      #1;
      chk_idle("R1 reset");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk_idle("R1 after reset");
      for (int k = 0; k < 32; k++)
         run_seq(32'h1 << k, 8'h01 << (k % 8), k[0]);
      run_seq(32'h0000_0000, 8'h00, 1'b0);
      run_seq(32'hFFFF_FFFF, 8'hFF, 1'b1);
      run_seq(32'hA5C3_0F81, 8'h80, 1'b1);
      run_seq(32'h0123_4567, 8'h55, 1'b0);
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule